// File: doc/BRIEF.md
# Instruction Fetch Next-Address Unit

This block owns the program counter of a single-cycle processor core. It drives the current program counter out as the instruction-memory address. On every clock edge it loads the next address, which is either the sequential successor or a branch destination. The control path supplies two inputs: a one-bit branch request and the ALU zero flag. The instruction supplies a 16-bit signed offset counted in words. A branch is taken only when the request and the zero flag are both high.

Two adders form the candidate addresses. The first steps the counter forward by one 4-byte word. The second adds the sign-extended offset to that stepped value, so a branch lands relative to the instruction that follows the branch. Addresses are always word aligned. All arithmetic wraps modulo 2^32.

The reset input is active low. It is applied asynchronously, and its release passes through a short synchronizer before the counter may move.

Top module: `ifetch_npc`

## Requirements
- R1: While `rst_n` is low the address output is 0, and it becomes 0 as soon as `rst_n` falls, without waiting for a clock edge. After `rst_n` rises, the address stays 0 across the next two rising clock edges and first advances on the third.
- R2: Bits [1:0] of the address output are 0 at all times.
- R3: When `br_sel_i` is 0, the next address is the current address plus 4. This holds for either value of `alu_zero_i` and for any offset.
- R4: When `br_sel_i` is 1 and `alu_zero_i` is 1, the next address is current + 4 + 4 × (the offset sign-extended from bit 15).
- R5: When `br_sel_i` is 1 and `alu_zero_i` is 0, the next address is current + 4, whatever the offset.
- R6: Both the sequential step and the branch sum wrap modulo 2^32. Stepping from 0xFFFFFFFC gives 0, and large backward or forward offsets wrap across the top or bottom of the address space.
- R7: An offset with bit 15 set moves the address backward. For example, 0xFFFF yields current + 0, and 0x8000 yields current + 4 − 0x20000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every update happens on its rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a synchronizer |
| imm_i | input | 16 | Signed word offset taken from the current instruction |
| br_sel_i | input | 1 | 1 = current instruction is a conditional branch, 0 = sequential |
| alu_zero_i | input | 1 | ALU zero flag for the current instruction |
| iaddr_o | output | 32 | Instruction-memory address (the program counter) |

## Verification
Every one of the 65536 offsets is applied as a taken branch. This confirms sign extension and word scaling for each bit pattern and separates forward jumps from backward ones. A separate sweep holds the offset at varied non-zero values while `br_sel_i` or `alu_zero_i` is low, so that a select built from either control alone, rather than their AND, shows up as a wrong address.

Hand-chosen offsets steer the counter to 0xFFFFFFFC and then across both ends of the address space, which exposes carries lost at the top. A reset asserted between clock edges, followed by the cycle count after release, checks the asynchronous clear and the synchronized start.

// File: rtl/ifn_pkg.sv
package ifn_pkg;
  // Source chosen for the next program-counter value
  typedef enum logic {
    NPC_SEQ = 1'b0,
    NPC_TGT = 1'b1
  } npc_src_e;
endpackage

// File: rtl/ifn_rst_sync.sv
module ifn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ifn_seq_adder.sv
// Steps a word index by one; wraps modulo 2^WORD_W.
module ifn_seq_adder #(
  parameter int WORD_W = 30
) (
  input  logic [WORD_W-1:0] pc_w_i,
  output logic [WORD_W-1:0] seq_w_o
);
  localparam logic [WORD_W-1:0] ONE_WORD = {{(WORD_W-1){1'b0}}, 1'b1};

  always_comb begin
    seq_w_o = pc_w_i + ONE_WORD;
  end
endmodule

// File: rtl/ifn_tgt_adder.sv
// Adds the sign-extended word offset to the stepped word index.
module ifn_tgt_adder #(
  parameter int WORD_W = 30,
  parameter int IMM_W  = 16
) (
  input  logic [WORD_W-1:0] base_w_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [WORD_W-1:0] tgt_w_o
);
  localparam int EXT_W = WORD_W - IMM_W;

  logic [WORD_W-1:0] off_w;

  always_comb begin
    off_w   = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    tgt_w_o = base_w_i + off_w;
  end
endmodule

// File: rtl/ifn_next_sel.sv
module ifn_next_sel
  import ifn_pkg::*;
#(
  parameter int WORD_W = 30
) (
  input  logic              br_sel_i,
  input  logic              zero_i,
  input  logic [WORD_W-1:0] seq_w_i,
  input  logic [WORD_W-1:0] tgt_w_i,
  output npc_src_e          src_o,
  output logic [WORD_W-1:0] next_w_o
);
  always_comb begin
    src_o = (br_sel_i && zero_i) ? NPC_TGT : NPC_SEQ;
    unique case (src_o)
      NPC_TGT: next_w_o = tgt_w_i;
      default: next_w_o = seq_w_i;
    endcase
  end
endmodule

// File: rtl/ifetch_npc.sv
module ifetch_npc
  import ifn_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IMM_W       = 16,
  parameter int ALIGN       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              br_sel_i,
  input  logic              alu_zero_i,
  output logic [ADDR_W-1:0] iaddr_o
);
  localparam int WORD_W = ADDR_W - ALIGN;

  logic              pc_run;
  logic              pc_en;
  logic [WORD_W-1:0] pc_q;
  logic [WORD_W-1:0] pc_d;
  logic [WORD_W-1:0] seq_w;
  logic [WORD_W-1:0] tgt_w;
  logic [WORD_W-1:0] next_w;
  npc_src_e          npc_src;

  ifn_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (pc_run)
  );

  ifn_seq_adder #(.WORD_W(WORD_W)) u_seq_add (
    .pc_w_i  (pc_q),
    .seq_w_o (seq_w)
  );

  ifn_tgt_adder #(.WORD_W(WORD_W), .IMM_W(IMM_W)) u_tgt_add (
    .base_w_i (seq_w),
    .imm_i    (imm_i),
    .tgt_w_o  (tgt_w)
  );

  ifn_next_sel #(.WORD_W(WORD_W)) u_next_sel (
    .br_sel_i (br_sel_i),
    .zero_i   (alu_zero_i),
    .seq_w_i  (seq_w),
    .tgt_w_i  (tgt_w),
    .src_o    (npc_src),
    .next_w_o (next_w)
  );

  // Next-state process with explicit clock enable
  always_comb begin
    pc_en = pc_run;
    pc_d  = pc_q;
    if (pc_en) pc_d = next_w;
  end

  always_ff @(posedge clk or negedge pc_run) begin
    if (!pc_run) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  // Low address bits are hardwired: only the word index is stored
  assign iaddr_o = {pc_q, {ALIGN{1'b0}}};
endmodule

// File: rtl/ifetch_npc_chk.sv
module ifetch_npc_chk #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int ALIGN  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic              br_sel_i,
  input logic              zero_i,
  input logic [ADDR_W-1:0] iaddr_i
);
  localparam int EXT_W = ADDR_W - IMM_W - ALIGN;
  localparam logic [ADDR_W-1:0] STEP = {{(ADDR_W-ALIGN-1){1'b0}}, 1'b1, {ALIGN{1'b0}}};

  logic [ADDR_W-1:0] off_c;
  assign off_c = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, {ALIGN{1'b0}}};

  // R1: counter held at zero until the synchronized release
  a_r1_held_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> iaddr_i == '0);

  // R3: sequential step when no branch is requested
  a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !br_sel_i) |=> iaddr_i == $past(iaddr_i) + STEP);

  // R4: taken branch lands at stepped address plus scaled offset
  a_r4_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && br_sel_i && zero_i) |=> iaddr_i == $past(iaddr_i + STEP + off_c));

  // R5: branch with zero flag low falls through
  a_r5_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && br_sel_i && !zero_i) |=> iaddr_i == $past(iaddr_i) + STEP);
endmodule

bind ifetch_npc ifetch_npc_chk #(
  .ADDR_W (ADDR_W),
  .IMM_W  (IMM_W),
  .ALIGN  (ALIGN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_i    (pc_run),
  .imm_i    (imm_i),
  .br_sel_i (br_sel_i),
  .zero_i   (alu_zero_i),
  .iaddr_i  (iaddr_o)
);

// File: tb/ifetch_npc_bench.sv
module ifetch_npc_bench;
  logic        clk;
  logic        rst_n;
  logic [15:0] imm;
  logic        br_sel;
  logic        zero;
  logic [31:0] iaddr;

  int          checks;
  int          fails;
  logic [31:0] pc_m;
  bit          done;

  ifetch_npc u_ifetch_npc (
    .clk        (clk),
    .rst_n      (rst_n),
    .imm_i      (imm),
    .br_sel_i   (br_sel),
    .alu_zero_i (zero),
    .iaddr_o    (iaddr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Called at a negedge: apply inputs, let one rising edge pass, compare
  task automatic step(input string req, input logic b, input logic z, input logic [15:0] im);
    logic [31:0] off;
    br_sel = b; zero = z; imm = im;
    off = {{14{im[15]}}, im, 2'b00};
    if (b && z) pc_m = pc_m + 32'd4 + off;
    else        pc_m = pc_m + 32'd4;
    @(negedge clk);
    chk(req, iaddr, pc_m);
    chk("R2", {30'd0, iaddr[1:0]}, 32'd0);
  endtask

  // Called at a negedge with rst_n already low
  task automatic finish_reset();
    br_sel = 1'b1; zero = 1'b1; imm = 16'h1234;
    repeat (3) begin
      @(negedge clk);
      chk("R1 held in reset", iaddr, 32'd0);
    end
    rst_n = 1'b1; br_sel = 1'b0; zero = 1'b0;
    @(negedge clk); chk("R1 first edge after release", iaddr, 32'd0);
    @(negedge clk); chk("R1 second edge after release", iaddr, 32'd0);
    @(negedge clk); chk("R1 third edge advances", iaddr, 32'd4);
    pc_m = 32'd4;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0; pc_m = '0;
    rst_n = 1'b0; br_sel = 1'b0; zero = 1'b0; imm = '0;
    @(negedge clk);
    chk("R1 reset value", iaddr, 32'd0);
    finish_reset();

    // R3: no branch request, offset and zero flag varied
    for (int i = 0; i < 256; i++) begin
      step("R3", 1'b0, i[0], 16'(i * 16'h0101 + 16'h8000));
    end
    step("R3", 1'b0, 1'b1, 16'h7FFF);

    // R5: branch requested but zero flag low
    for (int i = 0; i < 256; i++) begin
      step("R5", 1'b1, 1'b0, 16'(i * 16'h0103 + 16'h0001));
    end

    // R4 and R7: every offset as a taken branch
    for (int i = 0; i < 65536; i++) begin
      if (i[15]) step("R7", 1'b1, 1'b1, 16'(i));
      else       step("R4", 1'b1, 1'b1, 16'(i));
    end
    step("R7", 1'b1, 1'b1, 16'hFFFF);

    // R1: asynchronous reset between edges
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1 chk("R1 async clear", iaddr, 32'd0);
    @(negedge clk);
    finish_reset();

    // R6: wrap across both ends of the address space
    step("R6 backward wrap", 1'b1, 1'b1, 16'h8000);
    chk("R6 value", iaddr, 32'hFFFE_0008);
    step("R6 approach top", 1'b1, 1'b1, 16'h7FFC);
    chk("R6 value", iaddr, 32'hFFFF_FFFC);
    step("R6 sequential wrap", 1'b0, 1'b0, 16'h0000);
    chk("R6 value", iaddr, 32'h0000_0000);
    step("R6 backward from zero", 1'b1, 1'b1, 16'h8000);
    chk("R6 value", iaddr, 32'hFFFE_0004);
    step("R6 forward wrap", 1'b1, 1'b1, 16'h7FFF);
    chk("R6 value", iaddr, 32'h0000_0004);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule